// File: doc/BRIEF.md
# Byte-Stepped Two-Wire Bus Master

This block is the master side of an SMBus/I2C controller that works one bus step at a time. It places a START, a repeated START, a STOP, one transmitted byte or one received byte on the open-drain SDA and SCL lines. After each step it raises the `si` flag, holds SCL low and shows a four-bit status vector. The vector is `{master, tx_mode, start_seen, stop_pending}`, with bit 3 as the most significant bit. The block never chains steps by itself. Control logic reads the vector and answers with a one-cycle `resp_valid` strobe, and that strobe clears `si`.

The answer carries four pieces. `resp_load` says whether a new byte is loaded into the shift register. `resp_sta` and `resp_sto` request a START and a STOP. `resp_ack` gives the acknowledge value the master returns for the byte just received. SCL runs at a fixed rate: one bit lasts four quarter periods, and each quarter lasts `QTR` clock cycles.

Top module: `smb_byte_master`

## Requirements
- R1: After reset, `si` is 0, `status` is 4'b0000, and both `scl_oe` and `sda_oe` are 0 (both lines released).
- R2: A `go` pulse while idle produces a START: SDA falls while SCL is released, then SCL is pulled low. After that, `si` is 1 and `status` is 4'b1110.
- R3: While `si` is 1, `scl_oe` stays 1. Only a `resp_valid` strobe clears `si`.
- R4: A byte is transmitted most significant bit first, and SDA changes only while SCL is low. After the ninth clock, `si` is 1 and `status` is 4'b1100. `ack_rx` is 1 when the slave held SDA low during that ninth clock, and 0 otherwise.
- R5: A response in the transmit state with `resp_load`=0 and no START or STOP request switches the master to receiving. Eight bits are assembled most significant bit first. Then `si` is 1, `status` is 4'b1000, and the byte is on `rd_data`.
- R6: In the receive state, the response first drives one acknowledge clock. SDA is low in that clock when `resp_ack`=1 (ACK) and released when `resp_ack`=0 (NACK).
- R7: A response with `resp_sto`=1 and `resp_sta`=0 produces a STOP: SDA rises while SCL is released. The block then returns to idle with `status` 4'b0000, both lines released and `si` left at 0.
- R8: A response with both `resp_sto` and `resp_sta` set produces the STOP first. At least 2*QTR clock cycles after the SDA rise, a START follows, and `si` is set again with `status` 4'b1110.
- R9: A response with `resp_sta`=1 and `resp_sto`=0 produces a repeated START with no STOP, ending with `si`=1 and `status` 4'b1110.
- R10: START and STOP requests clear themselves once their condition is on the bus. A STOP is issued exactly once, and `status[0]` is 0 whenever `si` rises.
- R11: A receive-state response with `resp_load`=1 sends the acknowledge clock, then transmits the loaded byte, and ends in `status` 4'b1100.
- R12: `resp_valid` while `si` is 0 has no effect, and `go` has no effect unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Request a START while idle |
| resp_valid | input | 1 | One-cycle response strobe; clears `si` |
| resp_load | input | 1 | Load `resp_data` into the shift register |
| resp_data | input | 8 | Byte to transmit (address plus R/W, or data) |
| resp_sta | input | 1 | Request a START or repeated START |
| resp_sto | input | 1 | Request a STOP |
| resp_ack | input | 1 | 1 = ACK, 0 = NACK for the byte just received |
| sda_in | input | 1 | Level sampled on the SDA line |
| si | output | 1 | Step-complete flag; SCL is held low while set |
| status | output | 4 | {master, tx_mode, start_seen, stop_pending} |
| ack_rx | output | 1 | 1 when the slave acknowledged the last transmitted byte |
| rd_data | output | 8 | Last received byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check, on every cycle, four things. SCL stays low while `si` is set, and `si` falls only after a response. SDA is stable while SCL is high inside a bit slot. The vector's shape is correct whenever the flag is up, and SCL is released whenever the master bit is clear. Other behaviour can only be shown by the bench's bus-level scenarios, using a slave model and a line monitor. This covers bit order on the wire, the ACK/NACK value seen by each side, and the choice between continue, STOP, STOP plus START and repeated START. It also covers the bus-free gap and the rule that stray strobes are ignored.

// File: rtl/smb_byte_master.sv
module smb_byte_master #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       resp_valid,
  input  logic       resp_load,
  input  logic [7:0] resp_data,
  input  logic       resp_sta,
  input  logic       resp_sto,
  input  logic       resp_ack,
  input  logic       sda_in,
  output logic       si,
  output logic [3:0] status,
  output logic       ack_rx,
  output logic [7:0] rd_data,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int CW = (QTR > 2) ? $clog2(QTR) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RSTART, S_TXB, S_RXB, S_ACKO, S_STOP, S_FREE, S_HOLD
  } st_t;
  typedef enum logic [1:0] {A_STOP, A_RST, A_TX, A_RX} act_t;

  st_t         st;
  act_t        act;
  logic [CW-1:0] cnt;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic        scl_lo, sda_lo, si_r, master, txm, stf, sta_req, sto_req, ackr, ack_lo;

  wire run  = (st != S_IDLE) && (st != S_HOLD);
  wire tick = run && (cnt == CW'(QTR - 1));

  function automatic act_t pick(input logic sto, input logic sta, input logic load);
    if (sto)       return A_STOP;
    else if (sta)  return A_RST;
    else if (load) return A_TX;
    else           return A_RX;
  endfunction

  function automatic st_t target(input act_t a);
    case (a)
      A_STOP:  return S_STOP;
      A_RST:   return S_RSTART;
      A_TX:    return S_TXB;
      default: return S_RXB;
    endcase
  endfunction

  assign si      = si_r;
  assign status  = {master, txm, stf, sto_req};
  assign ack_rx  = ackr;
  assign rd_data = sh;
  assign scl_oe  = scl_lo;
  assign sda_oe  = sda_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act <= A_RX; cnt <= '0; q <= '0; bitn <= '0; sh <= '0;
      scl_lo <= 1'b0; sda_lo <= 1'b0; si_r <= 1'b0; master <= 1'b0; txm <= 1'b0;
      stf <= 1'b0; sta_req <= 1'b0; sto_req <= 1'b0; ackr <= 1'b0; ack_lo <= 1'b0;
    end else begin
      cnt <= (tick || !run) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (go) begin
          sta_req <= 1'b1;
          st      <= S_START;
          q       <= '0;
        end
        S_START: if (tick) begin
          if (q == 2'd0) begin
            sda_lo <= 1'b1;
            q      <= 2'd1;
          end else begin
            scl_lo <= 1'b1; si_r <= 1'b1; master <= 1'b1; txm <= 1'b1;
            stf <= 1'b1; sta_req <= 1'b0; st <= S_HOLD; q <= '0;
          end
        end
        S_RSTART: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin
              scl_lo <= 1'b1; si_r <= 1'b1; master <= 1'b1; txm <= 1'b1;
              stf <= 1'b1; sta_req <= 1'b0; st <= S_HOLD;
            end
          endcase
        end
        S_TXB: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_lo <= bitn[3] ? 1'b0 : ~sh[7];
            2'd1: scl_lo <= 1'b0;
            2'd2: if (bitn[3]) ackr <= ~sda_in;
            default: begin
              scl_lo <= 1'b1;
              if (bitn[3]) begin
                si_r <= 1'b1;
                st   <= S_HOLD;
              end else begin
                sh   <= {sh[6:0], 1'b0};
                bitn <= bitn + 4'd1;
              end
            end
          endcase
        end
        S_RXB: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sh <= {sh[6:0], sda_in};
            default: begin
              scl_lo <= 1'b1;
              if (bitn == 4'd7) begin
                si_r <= 1'b1;
                st   <= S_HOLD;
              end else begin
                bitn <= bitn + 4'd1;
              end
            end
          endcase
        end
        S_ACKO: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_lo <= ack_lo;
            2'd1: scl_lo <= 1'b0;
            2'd2: ;
            default: begin
              scl_lo <= 1'b1;
              st     <= target(act);
              bitn   <= '0;
              if (act == A_TX) txm <= 1'b1;
            end
          endcase
        end
        S_STOP: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_lo <= 1'b1;
            2'd1: scl_lo <= 1'b0;
            default: begin
              sda_lo <= 1'b0; master <= 1'b0; txm <= 1'b0; sto_req <= 1'b0;
              st <= S_FREE; q <= '0;
            end
          endcase
        end
        S_FREE: if (tick) begin
          if (q == 2'd1) begin
            st <= sta_req ? S_START : S_IDLE;
            q  <= '0;
          end else begin
            q <= 2'd1;
          end
        end
        S_HOLD: if (resp_valid) begin
          si_r    <= 1'b0;
          stf     <= 1'b0;
          sta_req <= resp_sta;
          sto_req <= resp_sto;
          q       <= '0;
          bitn    <= '0;
          if (resp_load) sh <= resp_data;
          if (!txm) begin
            ack_lo <= resp_ack;
            act    <= pick(resp_sto, resp_sta, resp_load);
            st     <= S_ACKO;
          end else begin
            st <= target(pick(resp_sto, resp_sta, resp_load));
            if (!resp_sto && !resp_sta && !resp_load) txm <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SCL_HELD_WHILE_SI: assert property (@(posedge clk) disable iff (!rst_n)
    si |-> scl_oe); // R3
  AST_SI_CLEARED_BY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si) |-> $past(resp_valid)); // R3
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st inside {S_TXB, S_RXB, S_ACKO}) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R4
  AST_RX_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (si && !status[2]) |-> (status == 4'b1000)); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] |-> !scl_oe); // R7
  AST_STOP_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> !status[0]); // R10

endmodule

// File: tb/test_smb_byte_master.sv
module test_smb_byte_master;
  localparam int QTR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 1'b0, resp_valid = 1'b0, resp_load = 1'b0, resp_sta = 1'b0, resp_sto = 1'b0, resp_ack = 1'b0;
  logic [7:0] resp_data = '0;
  logic si, ack_rx, scl_oe, sda_oe;
  logic [3:0] status;
  logic [7:0] rd_data;

  logic [9:0] pat = '0;
  logic slv_rst = 1'b0;
  int idx = 0;
  logic scl_q = 1'b1, sda_q = 1'b1;
  logic [15:0] bits = '0;
  int nb = 0, starts = 0, stops = 0, cyc = 0, t_start = 0, t_stop = 0;
  int n_tests = 0, n_fail = 0;

  wire slv_pull = (idx <= 9) ? pat[idx] : 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_pull);

  always #2.5 clk = ~clk;

  smb_byte_master #(.QTR(QTR)) i_smb_byte_master (
    .clk(clk), .rst_n(rst_n), .go(go), .resp_valid(resp_valid), .resp_load(resp_load),
    .resp_data(resp_data), .resp_sta(resp_sta), .resp_sto(resp_sto), .resp_ack(resp_ack),
    .sda_in(sda), .si(si), .status(status), .ack_rx(ack_rx), .rd_data(rd_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    scl_q <= scl;
    sda_q <= sda;
    if (slv_rst) begin
      idx <= 0;
      nb  <= 0;
    end else begin
      if (scl_q && !scl && idx < 10) idx <= idx + 1;
      if (!scl_q && scl) begin
        bits <= {bits[14:0], sda};
        nb   <= nb + 1;
      end
    end
    if (scl && scl_q && sda_q && !sda) begin starts <= starts + 1; t_start <= cyc; end
    if (scl && scl_q && !sda_q && sda) begin stops <= stops + 1; t_stop <= cyc; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] tx_pat(input bit ack, input int off);
    logic [9:0] p = '0;
    p[8 + off] = ack;
    return p;
  endfunction

  function automatic logic [9:0] rx_pat(input logic [7:0] d, input int off);
    logic [9:0] p = '0;
    for (int i = 0; i < 8; i++) p[i + off] = ~d[7 - i];
    return p;
  endfunction

  task automatic wait_si();
    for (int i = 0; i < 3000 && !si; i++) @(negedge clk);
    chk(si, "R3 step completes", si, 1);
  endtask

  task automatic resp(input bit ld, input logic [7:0] d, input bit sta, input bit sto, input bit ack, input logic [9:0] p);
    @(negedge clk);
    resp_valid = 1; resp_load = ld; resp_data = d; resp_sta = sta; resp_sto = sto; resp_ack = ack;
    pat = p; slv_rst = 1;
    @(negedge clk);
    resp_valid = 0; resp_load = 0; resp_sta = 0; resp_sto = 0; resp_ack = 0; slv_rst = 0;
  endtask

  task automatic start_from_idle();
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    wait_si();
  endtask

  task automatic finish_stop(input bit from_rx);
    int s0 = stops;
    resp(0, 8'h00, 0, 1, 0, '0);
    repeat (12 * QTR + 10) @(negedge clk);
    chk(stops == s0 + 1, "R7 single stop", stops, s0 + 1);
    chk(status == 4'b0000 && !si && !scl_oe && !sda_oe, "R7 idle after stop", {si, status, scl_oe, sda_oe}, 0);
  endtask

  initial begin
    int s0, b0;
    logic [7:0] d;
    bit a, in_rx;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(si == 0 && status == 0 && !scl_oe && !sda_oe, "R1 reset state", {si, status, scl_oe, sda_oe}, 0);

    resp(1, 8'hFF, 1, 1, 1, '0);
    repeat (50) @(negedge clk);
    chk(status == 0 && starts == 0 && !si && !scl_oe, "R12 response while idle", {starts, status}, 0);

    start_from_idle();
    chk(status == 4'b1110, "R2 start vector", status, 4'b1110);
    chk(starts == 1, "R2 start condition seen", starts, 1);
    repeat (20) @(negedge clk);
    chk(si && scl_oe, "R3 SCL held while SI", {si, scl_oe}, 2'b11);

    resp(1, 8'hA4, 0, 0, 0, tx_pat(1, 0));
    wait_si();
    chk(bits[8:1] == 8'hA4, "R4 address bits MSB first", bits[8:1], 8'hA4);
    chk(ack_rx == 1 && status == 4'b1100, "R4 ACK and vector", {ack_rx, status}, 5'b11100);

    s0 = starts;
    resp(1, 8'h3C, 0, 0, 0, tx_pat(0, 0));
    @(negedge clk); go = 1; resp_valid = 1; resp_load = 1; resp_data = 8'h11; resp_sto = 1;
    @(negedge clk); go = 0; resp_valid = 0; resp_load = 0; resp_sto = 0;
    wait_si();
    chk(bits[8:1] == 8'h3C && starts == s0, "R12 strobes during transfer ignored", bits[8:1], 8'h3C);
    chk(ack_rx == 0 && status == 4'b1100, "R4 NACK reported", {ack_rx, status}, 5'b01100);

    s0 = starts; b0 = stops;
    resp(0, 8'h00, 1, 0, 0, '0);
    wait_si();
    chk(status == 4'b1110 && starts == s0 + 1 && stops == b0, "R9 repeated start", {status, starts - s0, stops - b0}, {4'b1110, 32'd1, 32'd0});

    resp(1, 8'hA5, 0, 0, 0, tx_pat(1, 0));
    wait_si();
    chk(status == 4'b1100 && ack_rx, "R4 read address acked", {ack_rx, status}, 5'b11100);

    resp(0, 8'h00, 0, 0, 0, rx_pat(8'h5A, 0));
    wait_si();
    chk(status == 4'b1000 && rd_data == 8'h5A, "R5 receive byte", {status, rd_data}, {4'b1000, 8'h5A});

    resp(0, 8'h00, 0, 0, 1, rx_pat(8'hC3, 1));
    wait_si();
    chk(bits[8] == 1'b0, "R6 ACK driven low", bits[8], 0);
    chk(rd_data == 8'hC3 && status == 4'b1000, "R5 second byte", rd_data, 8'hC3);

    resp(1, 8'h77, 0, 0, 0, tx_pat(1, 1));
    wait_si();
    chk(bits[9] == 1'b1, "R6 NACK releases SDA", bits[9], 1);
    chk(bits[8:1] == 8'h77 && status == 4'b1100, "R11 receive to transmit", {status, bits[8:1]}, {4'b1100, 8'h77});

    finish_stop(0);
    repeat (100) @(negedge clk);
    chk(!si && stops == b0 + 1, "R10 no second stop or step", {si, stops - b0}, 1);

    start_from_idle();
    resp(1, 8'h52, 0, 0, 0, tx_pat(1, 0));
    wait_si();
    s0 = starts; b0 = stops;
    resp(0, 8'h00, 1, 1, 0, '0);
    wait_si();
    chk(status == 4'b1110 && stops == b0 + 1 && starts == s0 + 1, "R8 stop then start", {status, stops - b0, starts - s0}, {4'b1110, 32'd1, 32'd1});
    chk(t_start - t_stop >= 2 * QTR, "R8 bus free gap", t_start - t_stop, 2 * QTR);
    finish_stop(0);

    for (int t = 0; t < 25; t++) begin
      start_from_idle();
      chk(status == 4'b1110, "R2 random start", status, 4'b1110);
      d = 8'($urandom); a = 1'($urandom);
      resp(1, d, 0, 0, 0, tx_pat(a, 0));
      wait_si();
      chk(bits[8:1] == d && ack_rx == a, "R4 random address", {ack_rx, bits[8:1]}, {a, d});
      in_rx = 0;
      if (a) begin
        for (int k = 0; k < 3; k++) begin
          d = 8'($urandom);
          if ($urandom % 2) begin
            resp(1, d, 0, 0, 1, tx_pat(1, in_rx ? 1 : 0));
            wait_si();
            chk(bits[8:1] == d && status == 4'b1100, "R11 random transmit", {status, bits[8:1]}, {4'b1100, d});
            in_rx = 0;
          end else begin
            resp(0, 8'h00, 0, 0, 1, rx_pat(d, in_rx ? 1 : 0));
            wait_si();
            chk(rd_data == d && status == 4'b1000, "R5 random receive", {status, rd_data}, {4'b1000, d});
            in_rx = 1;
          end
        end
      end
      finish_stop(in_rx);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule